// File: doc/BRIEF.md
# Reset Sequencing and Latch Controller

This block drives the active-low system reset of a chip domain from a rail-good input and a set of fault requests. Any trip source must persist for a programmed interval before reset is asserted, so short spikes are filtered out. At the moment of assertion the block records which source caused it. Release always passes through a release delay that covers regulator settling and processor bootstrap. The release is also gated on a clock-good indication, so the domain never leaves reset on an unlocked clock.

A mode input selects one of three reset behaviours:

- **Hold** keeps reset low for as long as a trip is present.
- **Stretch** adds a minimum low window after the trip clears, sized for clock lock. A ceiling on that window forces a release attempt so boot cannot hang. It also sets a sticky flag.
- **Latch** keeps reset low until software or a sequencer issues an explicit clear. The clear only counts while power is good and the processor reports ready.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is 0, `last_src` is 0 and `stretch_timeout` is 0. After `rst_n` rises the block starts in the asserted state and behaves as if a trip has just ended.
- R2: A trip is `rail_good` low or any `fault_req` bit high. `rst_out_n` falls right after the edge on which the trip has been sampled on ASSERT_DLY+1 consecutive edges. A trip seen on ASSERT_DLY edges or fewer leaves `rst_out_n` high.
- R3: `last_src` is loaded on the asserting edge and holds its value at all other times. Its encoding is: 0 means rail undervoltage, which wins over any fault. k+1 means `fault_req[k]`, and the lowest index wins among faults.
- R4: With `mode_sel` = 0 (hold; 3 behaves the same), reset stays low while a trip is present. The release delay starts on the first edge that sees no trip.
- R5: Once the release delay has started, `rst_out_n` rises on the (RELEASE_DLY+1)-th following edge if no trip is sampled in between. A trip sampled during the release delay restarts the count, and reset stays low.
- R6: Reset is released only on an edge where `clock_good` is high. Otherwise the block waits with the delay already served. The one exception is a release forced by the stretch ceiling (R8).
- R7: With `mode_sel` = 1 (stretch), the trip ending opens a stretch window. The window lasts STRETCH_LEN+1 edges and also needs `clock_good`; the release delay of R5 follows it. A trip during the window returns the block to holding, and the window restarts when the trip ends.
- R8: If `clock_good` stays low, the stretch ends at the ceiling, STRETCH_MAX+1 edges after it opened. At that point `stretch_timeout` is set, and the following release ignores `clock_good`. `stretch_timeout` stays 1 until `rst_n`.
- R9: With `mode_sel` = 2 (latch), reset stays low after the trip ends. The release delay starts only on an edge that samples `clear`, `rail_good` and `mcu_ok` all high. A `clear` seen without both qualifiers is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| mode_sel | input | 2 | 0/3 hold, 1 stretch, 2 latch |
| rail_good | input | 1 | Qualified rail within limits |
| clock_good | input | 1 | Clock source locked and valid |
| mcu_ok | input | 1 | Processor ready acknowledgement (latch clear qualifier) |
| clear | input | 1 | Explicit latch clear request |
| fault_req | input | NUM_SRC | Per-source reset requests |
| rst_out_n | output | 1 | Active-low system reset |
| last_src | output | $clog2(NUM_SRC+1) | Tag of the source that last asserted reset |
| stretch_timeout | output | 1 | Sticky flag: a stretch reached its ceiling |

## Verification
The bench builds the block with NUM_SRC=3, ASSERT_DLY=3, STRETCH_LEN=8, STRETCH_MAX=20 and RELEASE_DLY=6. These short intervals make every window boundary easy to probe: the one-cycle-short glitch, a release-delay restart, and the stretch ceiling. Each is checked on the exact edge where the output must change and on the edge just before it. With three fault sources, random fault patterns cover lowest-index priority, rail-over-fault priority, and tag retention across a release.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   typedef enum logic [1:0] {
      MD_HOLD    = 2'd0,
      MD_STRETCH = 2'd1,
      MD_LATCH   = 2'd2,
      MD_SPARE   = 2'd3
   } rsc_mode_e;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_ARM,
      ST_HOLD,
      ST_STRETCH,
      ST_RELEASE
   } rsc_state_e;

endpackage

// File: rtl/rsc_src_encoder.sv
module rsc_src_encoder #(
   parameter int NUM_SRC = 3,
   parameter int TAG_W   = 2
) (
   input  logic               rail_good,
   input  logic [NUM_SRC-1:0] fault_req,
   output logic               trip,
   output logic [TAG_W-1:0]   trip_tag
);

   always_comb begin
      trip     = !rail_good || (|fault_req);
      trip_tag = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (fault_req[i]) begin
            trip_tag = TAG_W'(i + 1);
         end
      end
      if (!rail_good) begin
         trip_tag = '0;
      end
   end

endmodule

// File: rtl/rsc_seq_fsm.sv
module rsc_seq_fsm
   import rsc_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int TAG_W       = 2,
   parameter int ASSERT_DLY  = 3,
   parameter int STRETCH_LEN = 8,
   parameter int STRETCH_MAX = 20,
   parameter int RELEASE_DLY = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_sel,
   input  logic             trip,
   input  logic [TAG_W-1:0] trip_tag,
   input  logic             rail_good,
   input  logic             clock_good,
   input  logic             mcu_ok,
   input  logic             clear,
   output logic             rst_out_n,
   output logic [TAG_W-1:0] last_src,
   output logic             stretch_timeout
);

   localparam logic [CNT_W-1:0] A_LIM   = CNT_W'(ASSERT_DLY);
   localparam logic [CNT_W-1:0] S_LIM   = CNT_W'(STRETCH_LEN);
   localparam logic [CNT_W-1:0] T_LIM   = CNT_W'(STRETCH_MAX);
   localparam logic [CNT_W-1:0] R_LIM   = CNT_W'(RELEASE_DLY);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   rsc_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [TAG_W-1:0] tag_q, tag_d;
   logic             force_q, force_d;
   logic             tmo_q, tmo_d;
   rsc_mode_e        mode;
   logic             clr_ok;

   assign mode   = rsc_mode_e'(mode_sel);
   assign clr_ok = clear && rail_good && mcu_ok;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      tag_d   = tag_q;
      force_d = force_q;
      tmo_d   = tmo_q;
      case (state_q)
         ST_RUN: begin
            if (trip) begin
               state_d = ST_ARM;
               cnt_d   = CNT_ONE;
            end
         end
         ST_ARM: begin
            if (!trip) begin
               state_d = ST_RUN;
               cnt_d   = '0;
            end else if (cnt_q == A_LIM) begin
               state_d = ST_HOLD;
               cnt_d   = '0;
               tag_d   = trip_tag;
            end else begin
               cnt_d = cnt_q + CNT_ONE;
            end
         end
         ST_HOLD: begin
            case (mode)
               MD_STRETCH: begin
                  if (!trip) begin
                     state_d = ST_STRETCH;
                     cnt_d   = '0;
                  end
               end
               MD_LATCH: begin
                  if (clr_ok) begin
                     state_d = ST_RELEASE;
                     cnt_d   = '0;
                  end
               end
               default: begin
                  if (!trip) begin
                     state_d = ST_RELEASE;
                     cnt_d   = '0;
                  end
               end
            endcase
         end
         ST_STRETCH: begin
            if (trip) begin
               state_d = ST_HOLD;
               cnt_d   = '0;
            end else if ((cnt_q >= S_LIM) && clock_good) begin
               state_d = ST_RELEASE;
               cnt_d   = '0;
            end else if (cnt_q == T_LIM) begin
               state_d = ST_RELEASE;
               cnt_d   = '0;
               force_d = 1'b1;
               tmo_d   = 1'b1;
            end else begin
               cnt_d = cnt_q + CNT_ONE;
            end
         end
         ST_RELEASE: begin
            if (trip) begin
               cnt_d = '0;
            end else if ((cnt_q >= R_LIM) && (clock_good || force_q)) begin
               state_d = ST_RUN;
               cnt_d   = '0;
               force_d = 1'b0;
            end else if (cnt_q < R_LIM) begin
               cnt_d = cnt_q + CNT_ONE;
            end
         end
         default: begin
            state_d = ST_HOLD;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
         cnt_q   <= '0;
         tag_q   <= '0;
         force_q <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         tag_q   <= tag_d;
         force_q <= force_d;
         tmo_q   <= tmo_d;
      end
   end

   assign rst_out_n       = (state_q == ST_RUN) || (state_q == ST_ARM);
   assign last_src        = tag_q;
   assign stretch_timeout = tmo_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
   parameter int NUM_SRC     = 3,
   parameter int CNT_W       = 12,
   parameter int ASSERT_DLY  = 3,
   parameter int STRETCH_LEN = 8,
   parameter int STRETCH_MAX = 20,
   parameter int RELEASE_DLY = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [1:0]                     mode_sel,
   input  logic                           rail_good,
   input  logic                           clock_good,
   input  logic                           mcu_ok,
   input  logic                           clear,
   input  logic [NUM_SRC-1:0]             fault_req,
   output logic                           rst_out_n,
   output logic [$clog2(NUM_SRC+1)-1:0]   last_src,
   output logic                           stretch_timeout
);

   localparam int TAG_W   = $clog2(NUM_SRC + 1);
   localparam int CNT_TOP = (1 << CNT_W) - 1;

   generate
      if (NUM_SRC < 1) begin : g_bad_src
         $error("rst_seq_ctrl: NUM_SRC must be at least 1");
      end
      if (ASSERT_DLY < 1) begin : g_bad_assert
         $error("rst_seq_ctrl: ASSERT_DLY must be at least 1");
      end
      if (STRETCH_MAX <= STRETCH_LEN) begin : g_bad_ceiling
         $error("rst_seq_ctrl: STRETCH_MAX must exceed STRETCH_LEN");
      end
      if ((STRETCH_MAX > CNT_TOP) || (RELEASE_DLY > CNT_TOP) ||
          (ASSERT_DLY > CNT_TOP)) begin : g_bad_width
         $error("rst_seq_ctrl: an interval does not fit in CNT_W bits");
      end
   endgenerate

   logic             trip;
   logic [TAG_W-1:0] trip_tag;

   rsc_src_encoder #(
      .NUM_SRC (NUM_SRC),
      .TAG_W   (TAG_W)
   ) u_enc (
      .rail_good (rail_good),
      .fault_req (fault_req),
      .trip      (trip),
      .trip_tag  (trip_tag)
   );

   rsc_seq_fsm #(
      .CNT_W       (CNT_W),
      .TAG_W       (TAG_W),
      .ASSERT_DLY  (ASSERT_DLY),
      .STRETCH_LEN (STRETCH_LEN),
      .STRETCH_MAX (STRETCH_MAX),
      .RELEASE_DLY (RELEASE_DLY)
   ) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .mode_sel        (mode_sel),
      .trip            (trip),
      .trip_tag        (trip_tag),
      .rail_good       (rail_good),
      .clock_good      (clock_good),
      .mcu_ok          (mcu_ok),
      .clear           (clear),
      .rst_out_n       (rst_out_n),
      .last_src        (last_src),
      .stretch_timeout (stretch_timeout)
   );

endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
   parameter int NUM_SRC = 3,
   parameter int TAG_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         mode_sel,
   input logic               rail_good,
   input logic               clock_good,
   input logic               mcu_ok,
   input logic               clear,
   input logic [NUM_SRC-1:0] fault_req,
   input logic               rst_out_n,
   input logic [TAG_W-1:0]   last_src,
   input logic               stretch_timeout
);

   logic qual_clear_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_clear_seen <= 1'b0;
      end else if (rst_out_n) begin
         qual_clear_seen <= 1'b0;
      end else if (clear && rail_good && mcu_ok) begin
         qual_clear_seen <= 1'b1;
      end
   end

   AST_FALL_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out_n) |-> $past(!rail_good || (|fault_req))); // R2

   AST_TAG_ONLY_ON_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(rst_out_n) |-> $stable(last_src)); // R3

   AST_RAIL_TAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rst_out_n) && $past(!rail_good)) |-> (last_src == '0)); // R3

   AST_NO_RELEASE_ON_BAD_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_out_n && !rail_good) |=> !rst_out_n); // R4

   AST_RELEASE_CLOCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n) |-> ($past(clock_good) || stretch_timeout)); // R6

   AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stretch_timeout |=> stretch_timeout); // R8

   AST_LATCH_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_out_n) && (mode_sel == 2'd2)) |-> qual_clear_seen); // R9

endmodule

bind rst_seq_ctrl rsc_chk #(
   .NUM_SRC (NUM_SRC),
   .TAG_W   ($clog2(NUM_SRC + 1))
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .mode_sel        (mode_sel),
   .rail_good       (rail_good),
   .clock_good      (clock_good),
   .mcu_ok          (mcu_ok),
   .clear           (clear),
   .fault_req       (fault_req),
   .rst_out_n       (rst_out_n),
   .last_src        (last_src),
   .stretch_timeout (stretch_timeout)
);

// File: tb/rst_seq_ctrl_tb.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb;

   localparam int NS  = 3;
   localparam int TW  = 2;
   localparam int A_D = 3;
   localparam int S_L = 8;
   localparam int T_M = 20;
   localparam int R_D = 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    mode_sel;
   logic          rail_good, clock_good, mcu_ok, clear;
   logic [NS-1:0] fault_req;
   logic          rst_out_n;
   logic [TW-1:0] last_src;
   logic          stretch_timeout;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   rst_seq_ctrl #(
      .NUM_SRC     (NS),
      .CNT_W       (8),
      .ASSERT_DLY  (A_D),
      .STRETCH_LEN (S_L),
      .STRETCH_MAX (T_M),
      .RELEASE_DLY (R_D)
   ) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .mode_sel        (mode_sel),
      .rail_good       (rail_good),
      .clock_good      (clock_good),
      .mcu_ok          (mcu_ok),
      .clear           (clear),
      .fault_req       (fault_req),
      .rst_out_n       (rst_out_n),
      .last_src        (last_src),
      .stretch_timeout (stretch_timeout)
   );

   function automatic logic [TW-1:0] exp_tag(logic rail, logic [NS-1:0] f);
      if (!rail) return '0;
      for (int i = 0; i < NS; i++) begin
         if (f[i]) return TW'(i + 1);
      end
      return '0;
   endfunction

   // edges from trip removal to release, per mode
   function automatic int hold_rel_edges();
      return R_D + 2;
   endfunction

   function automatic int stretch_rel_edges();
      return S_L + R_D + 3;
   endfunction

   function automatic int tmo_rel_edges();
      return T_M + R_D + 3;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic trip_by_rail();
      @(negedge clk);
      rail_good = 1'b0;
      edges(A_D + 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; mode_sel = 2'd0; rail_good = 1'b1; clock_good = 1'b1;
      mcu_ok = 1'b0; clear = 1'b0; fault_req = '0;
      edges(3);
      chk("R1 rst_out_n", rst_out_n, 0);
      chk("R1 last_src", last_src, 0);
      chk("R1 timeout", stretch_timeout, 0);

      // power-on release after reset, hold mode
      @(negedge clk);
      rst_n = 1'b1;
      edges(hold_rel_edges() - 1);
      chk("R1 still low before release", rst_out_n, 0);
      edges(1);
      chk("R1 released", rst_out_n, 1);

      // R2 exact assert delay
      @(negedge clk);
      rail_good = 1'b0;
      edges(A_D);
      chk("R2 high one edge short", rst_out_n, 1);
      edges(1);
      chk("R2 low after delay", rst_out_n, 0);
      chk("R3 rail tag", last_src, 0);
      @(negedge clk);
      rail_good = 1'b1;
      edges(hold_rel_edges() - 1);
      chk("R4 low before release", rst_out_n, 0);
      edges(1);
      chk("R5 hold release", rst_out_n, 1);

      // R2 random short glitches never assert
      for (int it = 0; it < 8; it++) begin
         int len;
         len = 1 + int'($urandom % A_D);
         @(negedge clk);
         if (it % 2 == 0) rail_good = 1'b0;
         else fault_req[$urandom % NS] = 1'b1;
         edges(len);
         @(negedge clk);
         rail_good = 1'b1;
         fault_req = '0;
         edges(3);
         chk("R2 glitch filtered", rst_out_n, 1);
      end

      // R3 random tag patterns
      for (int it = 0; it < 6; it++) begin
         logic [NS-1:0] f;
         logic          r;
         logic [TW-1:0] et;
         f  = NS'(1 + ($urandom % ((1 << NS) - 1)));
         r  = (($urandom % 4) == 0) ? 1'b0 : 1'b1;
         et = exp_tag(r, f);
         @(negedge clk);
         fault_req = f;
         rail_good = r;
         edges(A_D + 1);
         chk("R3 asserted", rst_out_n, 0);
         chk("R3 tag priority", last_src, et);
         @(negedge clk);
         fault_req = '0;
         rail_good = 1'b1;
         edges(hold_rel_edges());
         chk("R4 released after faults", rst_out_n, 1);
         chk("R3 tag kept after release", last_src, et);
      end

      // R5 restart of release delay
      trip_by_rail();
      @(negedge clk);
      rail_good = 1'b1;
      edges(3);
      @(negedge clk);
      rail_good = 1'b0;
      edges(1);
      chk("R5 low on rail drop", rst_out_n, 0);
      @(negedge clk);
      rail_good = 1'b1;
      edges(R_D);
      chk("R5 restarted count still low", rst_out_n, 0);
      edges(1);
      chk("R5 release after restart", rst_out_n, 1);

      // R6 clock-good gate
      trip_by_rail();
      @(negedge clk);
      rail_good = 1'b1;
      clock_good = 1'b0;
      edges(R_D + 7);
      chk("R6 held for clock", rst_out_n, 0);
      @(negedge clk);
      clock_good = 1'b1;
      edges(1);
      chk("R6 release on clock good", rst_out_n, 1);

      // R7 stretch window
      @(negedge clk);
      mode_sel = 2'd1;
      begin
         int k;
         k = int'($urandom % NS);
         fault_req[k] = 1'b1;
         edges(A_D + 1);
         chk("R7 asserted", rst_out_n, 0);
         chk("R3 fault tag", last_src, k + 1);
         @(negedge clk);
         fault_req = '0;
         edges(stretch_rel_edges() - 1);
         chk("R7 stretch low", rst_out_n, 0);
         edges(1);
         chk("R7 stretch release", rst_out_n, 1);
      end

      // R7 trip inside stretch restarts the window
      trip_by_rail();
      @(negedge clk);
      rail_good = 1'b1;
      edges(4);
      @(negedge clk);
      rail_good = 1'b0;
      edges(1);
      @(negedge clk);
      rail_good = 1'b1;
      edges(stretch_rel_edges() - 1);
      chk("R7 window restarted", rst_out_n, 0);
      edges(1);
      chk("R7 release after restart", rst_out_n, 1);

      // R8 stretch ceiling
      chk("R8 no timeout yet", stretch_timeout, 0);
      trip_by_rail();
      @(negedge clk);
      rail_good = 1'b1;
      clock_good = 1'b0;
      edges(T_M + 1);
      chk("R8 flag not before ceiling", stretch_timeout, 0);
      edges(1);
      chk("R8 flag at ceiling", stretch_timeout, 1);
      edges(tmo_rel_edges() - T_M - 3);
      chk("R8 low before forced release", rst_out_n, 0);
      edges(1);
      chk("R8 forced release without clock", rst_out_n, 1);
      @(negedge clk);
      clock_good = 1'b1;
      edges(5);
      chk("R8 flag sticky", stretch_timeout, 1);

      // R9 latch mode
      @(negedge clk);
      mode_sel = 2'd2;
      trip_by_rail();
      chk("R9 asserted", rst_out_n, 0);
      @(negedge clk);
      rail_good = 1'b1;
      edges(30);
      chk("R9 latched after trip gone", rst_out_n, 0);
      @(negedge clk);
      clear = 1'b1;
      mcu_ok = 1'b0;
      @(negedge clk);
      clear = 1'b0;
      edges(R_D + 5);
      chk("R9 clear without mcu_ok ignored", rst_out_n, 0);
      @(negedge clk);
      clear = 1'b1;
      mcu_ok = 1'b1;
      rail_good = 1'b0;
      @(negedge clk);
      clear = 1'b0;
      mcu_ok = 1'b0;
      rail_good = 1'b1;
      edges(R_D + 5);
      chk("R9 clear with bad rail ignored", rst_out_n, 0);
      @(negedge clk);
      clear = 1'b1;
      mcu_ok = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      mcu_ok = 1'b0;
      edges(R_D);
      chk("R9 release delay after clear", rst_out_n, 0);
      edges(1);
      chk("R9 released by qualified clear", rst_out_n, 1);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule